// File: doc/BRIEF.md
# Converter Register Interface

This block is the bus-facing register set placed in front of a 12-bit successive-approximation converter core. A simple word-addressed bus with separate read and write strobes reaches a control register, a negative-input select field, a ready status flag, the captured conversion result, a soft-reset trigger and two 10-bit calibration registers (gain and offset). The converter core supplies a one-cycle done pulse with its result and a busy level. The block returns a channel code, an interrupt and a gated busy signal for an external pin.

Software starts conversions elsewhere and then waits on the interrupt or polls the status flag. Reading the result register consumes the result and drops the flag. Writing anything to the reset register puts every register back to its power-up value without touching the bus reset.

Top module: `adc_regif`

## Requirements
- R1: After reset, control reads 0, select 0, status 0, result 0, gain 0x200, offset 0x200, and the interrupt is low.
- R2: A done pulse sets the ready flag, which reads as bit 0 of status (word address 2) with bits 31:1 zero. The interrupt output equals the flag.
- R3: The result register (word address 3) loads the 12-bit converter result only on a done pulse and holds it otherwise. It reads zero-extended.
- R4: A bus read of the result register clears the ready flag on that clock edge, so the interrupt drops.
- R5: When a done pulse and a result read fall in the same cycle, the read returns the previous result and the flag stays set.
- R6: A write of any value to the reset register (word address 4) returns all registers to their R1 values at the next edge. This takes priority over a done pulse in the same cycle.
- R7: Gain (word address 5) and offset (word address 6) store write bits 9:0, ignore the upper bits, and read back zero-extended.
- R8: Writes to the status and result registers have no effect.
- R9: The select register (word address 1) stores write bits 4:0 and reads with bits 31:5 zero.
- R10: The channel output passes select codes 0 to 16 unchanged (16 is the internal-reference self-test). Codes 17 to 31 drive 0.
- R11: The busy pin follows the converter busy input while control bit 0 (word address 0) is 1, and is 0 otherwise. Control stores only bit 0.
- R12: A read of the reset register or of the unmapped word address 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| conv_done | input | 1 | One-cycle end-of-conversion pulse |
| conv_result | input | 12 | Converter result, valid with conv_done |
| conv_busy | input | 1 | Converter busy level |
| neg_chan | output | 5 | Negative-input channel code |
| adc_irq | output | 1 | Interrupt level |
| busy_pin | output | 1 | Gated busy level |

## Verification
The flag and capture assertions assume conv_done is a single-cycle pulse and that conv_result is valid in the cycle it is high. The bench drives each done pulse for exactly one cycle, with the result alongside it. The properties also assume the strobes are clean levels sampled at the edge. The bench changes strobes, addresses and data only on the falling clock edge, and raises at most one register access per cycle, except in the deliberate collision cases for R5 and R6.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL = 3'd0,
      A_NSEL = 3'd1,
      A_STAT = 3'd2,
      A_DATA = 3'd3,
      A_SRST = 3'd4,
      A_GAIN = 3'd5,
      A_OFFS = 3'd6,
      A_NONE = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/adc_ready_flag.sv
module adc_ready_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_clr,
   input  logic set_i,
   input  logic rd_clr_i,
   output logic ready_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ready_o <= 1'b0;
      else if (soft_clr) ready_o <= 1'b0;
      else if (set_i)    ready_o <= 1'b1;
      else if (rd_clr_i) ready_o <= 1'b0;
   end

   // R2
   set_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i && !soft_clr |=> ready_o);
   // R5
   set_beats_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i && rd_clr_i && !soft_clr |=> ready_o);
   // R4
   clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr_i && !set_i |=> !ready_o);
   // R6
   soft_clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> !ready_o);
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] res_i,
   output logic [DATA_W-1:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_o <= '0;
      else if (soft_clr) data_o <= '0;
      else if (cap_i)    data_o <= res_i;
   end

   // R3
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i && !soft_clr |=> $stable(data_o));
   // R3
   result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i && !soft_clr |=> data_o == $past(res_i));
endmodule

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg #(
   parameter int           W       = 10,
   parameter logic [W-1:0] DEFAULT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o <= DEFAULT;
      else if (soft_clr) q_o <= DEFAULT;
      else if (we_i)     q_o <= wdata_i;
   end

   // R6
   cfg_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> q_o == DEFAULT);
   // R7
   cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i && !soft_clr |=> q_o == $past(wdata_i));
endmodule

// File: rtl/adc_chan_map.sv
module adc_chan_map #(
   parameter int SEL_W    = 5,
   parameter int SEL_LAST = 16
) (
   input  logic [SEL_W-1:0] code_i,
   output logic [SEL_W-1:0] chan_o
);
   localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(SEL_LAST);

   always_comb begin
      chan_o = (code_i > LAST_CODE) ? '0 : code_i;
   end

   always_comb begin
      // R10
      chan_range_chk: assert (chan_o <= LAST_CODE);
   end
endmodule

// File: rtl/adc_regif.sv
module adc_regif
   import adc_regif_pkg::*;
#(
   parameter int             DATA_W      = 12,
   parameter int             CAL_W       = 10,
   parameter logic [CAL_W-1:0] CAL_DEFAULT = 10'h200,
   parameter int             SEL_W       = 5,
   parameter int             SEL_LAST    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   input  logic              conv_busy,
   output logic [SEL_W-1:0]  neg_chan,
   output logic              adc_irq,
   output logic              busy_pin
);
   localparam int N_CAL = 2;

   if (DATA_W > BUS_W || CAL_W > BUS_W || SEL_W > BUS_W) begin : g_width_bad
      $error("adc_regif: register wider than bus");
   end
   if (SEL_LAST >= (1 << SEL_W)) begin : g_sel_bad
      $error("adc_regif: SEL_LAST does not fit SEL_W");
   end

   reg_addr_e   addr;
   logic        soft_clr;
   logic        ready;
   logic        ctrl_q;
   logic [SEL_W-1:0]  nsel_q;
   logic [DATA_W-1:0] data_q;
   logic [CAL_W-1:0]  cal_q  [N_CAL];
   logic [N_CAL-1:0]  cal_we;

   assign addr     = reg_addr_e'(bus_addr);
   assign soft_clr = bus_wr && (addr == A_SRST);

   adc_ready_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .set_i    (conv_done),
      .rd_clr_i (bus_rd && (addr == A_DATA)),
      .ready_o  (ready)
   );

   adc_result_reg #(.DATA_W(DATA_W)) u_result (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .cap_i    (conv_done),
      .res_i    (conv_result),
      .data_o   (data_q)
   );

   adc_cfg_reg #(.W(1), .DEFAULT(1'b0)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .we_i     (bus_wr && (addr == A_CTRL)),
      .wdata_i  (bus_wdata[0]),
      .q_o      (ctrl_q)
   );

   adc_cfg_reg #(.W(SEL_W), .DEFAULT('0)) u_nsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .we_i     (bus_wr && (addr == A_NSEL)),
      .wdata_i  (bus_wdata[SEL_W-1:0]),
      .q_o      (nsel_q)
   );

   assign cal_we[0] = bus_wr && (addr == A_GAIN);
   assign cal_we[1] = bus_wr && (addr == A_OFFS);

   for (genvar g = 0; g < N_CAL; g++) begin : g_cal
      adc_cfg_reg #(.W(CAL_W), .DEFAULT(CAL_DEFAULT)) u_cal (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_clr (soft_clr),
         .we_i     (cal_we[g]),
         .wdata_i  (bus_wdata[CAL_W-1:0]),
         .q_o      (cal_q[g])
      );
   end

   adc_chan_map #(.SEL_W(SEL_W), .SEL_LAST(SEL_LAST)) u_chan (
      .code_i (nsel_q),
      .chan_o (neg_chan)
   );

   always_comb begin
      bus_rdata = '0;
      case (addr)
         A_CTRL:  bus_rdata = BUS_W'(ctrl_q);
         A_NSEL:  bus_rdata = BUS_W'(nsel_q);
         A_STAT:  bus_rdata = BUS_W'(ready);
         A_DATA:  bus_rdata = BUS_W'(data_q);
         A_GAIN:  bus_rdata = BUS_W'(cal_q[0]);
         A_OFFS:  bus_rdata = BUS_W'(cal_q[1]);
         default: bus_rdata = '0;
      endcase
   end

   assign adc_irq  = ready;
   assign busy_pin = conv_busy & ctrl_q;

   // R11
   busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_pin |-> conv_busy && ctrl_q);
   // R2
   status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr == A_STAT |-> bus_rdata[BUS_W-1:1] == '0);
endmodule

// File: tb/adc_regif_tb.sv
module adc_regif_tb_top;
   import adc_regif_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        conv_done = 1'b0;
   logic [11:0] conv_result = '0;
   logic        conv_busy = 1'b0;
   logic [4:0]  neg_chan;
   logic        adc_irq;
   logic        busy_pin;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   adc_regif dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .conv_done(conv_done), .conv_result(conv_result), .conv_busy(conv_busy),
      .neg_chan(neg_chan), .adc_irq(adc_irq), .busy_pin(busy_pin)
   );

   typedef struct packed {
      logic        rd;
      logic [3:0]  req;
      logic [2:0]  a;
      logic [31:0] d;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'd7,  3'd5, 32'hFFFF_F155}, '{1'b1, 4'd7,  3'd5, 32'h0000_0155},
      '{1'b0, 4'd7,  3'd6, 32'h0000_03FF}, '{1'b1, 4'd7,  3'd6, 32'h0000_03FF},
      '{1'b0, 4'd7,  3'd6, 32'h0000_0400}, '{1'b1, 4'd7,  3'd6, 32'h0000_0000},
      '{1'b0, 4'd9,  3'd1, 32'h0000_00FF}, '{1'b1, 4'd9,  3'd1, 32'h0000_001F},
      '{1'b0, 4'd9,  3'd1, 32'h0000_0010}, '{1'b1, 4'd9,  3'd1, 32'h0000_0010},
      '{1'b0, 4'd11, 3'd0, 32'hFFFF_FFFE}, '{1'b1, 4'd11, 3'd0, 32'h0000_0000},
      '{1'b0, 4'd11, 3'd0, 32'h0000_0003}, '{1'b1, 4'd11, 3'd0, 32'h0000_0001},
      '{1'b0, 4'd8,  3'd2, 32'hFFFF_FFFF}, '{1'b1, 4'd8,  3'd2, 32'h0000_0000},
      '{1'b0, 4'd8,  3'd3, 32'h0000_0FFF}, '{1'b1, 4'd8,  3'd3, 32'h0000_0000},
      '{1'b1, 4'd12, 3'd7, 32'h0000_0000}, '{1'b1, 4'd12, 3'd4, 32'h0000_0000}
   };

   function automatic string req_name(input logic [3:0] n);
      case (n)
         4'd7:    return "R7";
         4'd8:    return "R8";
         4'd9:    return "R9";
         4'd11:   return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic convert(input logic [11:0] r);
      @(negedge clk);
      conv_done = 1'b1; conv_result = r;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(3'd0, v); chk("R1 ctrl", v, 32'h0);
      bus_read(3'd1, v); chk("R1 nsel", v, 32'h0);
      bus_read(3'd2, v); chk("R1 status", v, 32'h0);
      bus_read(3'd3, v); chk("R1 data", v, 32'h0);
      bus_read(3'd5, v); chk("R1 gain", v, 32'h200);
      bus_read(3'd6, v); chk("R1 offset", v, 32'h200);
      chk("R1 irq", 32'(adc_irq), 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].rd) begin
            bus_read(VECS[i].a, v);
            chk(req_name(VECS[i].req), v, VECS[i].d);
         end else begin
            bus_write(VECS[i].a, VECS[i].d);
         end
      end

      // R11 busy gating, control currently 1
      conv_busy = 1'b1; #1;
      chk("R11 busy enabled", 32'(busy_pin), 32'h1);
      bus_write(3'd0, 32'h0); #1;
      chk("R11 busy disabled", 32'(busy_pin), 32'h0);
      conv_busy = 1'b0;

      // R10 channel mapping, select holds 16
      #1 chk("R10 code 16", 32'(neg_chan), 32'd16);
      bus_write(3'd1, 32'h11); #1;
      chk("R10 code 17", 32'(neg_chan), 32'd0);
      bus_read(3'd1, v); chk("R9 reserved stored", v, 32'h11);
      bus_write(3'd1, 32'h1F); #1;
      chk("R10 code 31", 32'(neg_chan), 32'd0);
      bus_write(3'd1, 32'h0F); #1;
      chk("R10 code 15", 32'(neg_chan), 32'd15);

      // R2 / R3 / R4 conversion flow
      convert(12'hABC); #1;
      chk("R2 irq set", 32'(adc_irq), 32'h1);
      bus_read(3'd2, v); chk("R2 status", v, 32'h1);
      chk("R2 irq held after status read", 32'(adc_irq), 32'h1);
      conv_result = 12'h111;
      bus_read(3'd3, v); chk("R3 data", v, 32'hABC);
      #1 chk("R4 irq cleared", 32'(adc_irq), 32'h0);
      bus_read(3'd2, v); chk("R4 status cleared", v, 32'h0);
      bus_read(3'd3, v); chk("R3 data held", v, 32'hABC);

      // R5 done and read collide
      convert(12'h555);
      @(negedge clk);
      bus_addr = 3'd3; bus_rd = 1'b1; conv_done = 1'b1; conv_result = 12'h123;
      #1 v = bus_rdata;
      chk("R5 read returns old", v, 32'h555);
      @(negedge clk);
      bus_rd = 1'b0; conv_done = 1'b0;
      #1 chk("R5 flag kept", 32'(adc_irq), 32'h1);
      bus_read(3'd3, v); chk("R5 new data", v, 32'h123);

      // R6 soft reset of everything
      bus_write(3'd5, 32'h3FF);
      bus_write(3'd0, 32'h1);
      convert(12'h777);
      bus_write(3'd4, 32'hDEAD_BEEF); #1;
      chk("R6 irq", 32'(adc_irq), 32'h0);
      chk("R6 chan", 32'(neg_chan), 32'h0);
      bus_read(3'd5, v); chk("R6 gain", v, 32'h200);
      bus_read(3'd0, v); chk("R6 ctrl", v, 32'h0);
      bus_read(3'd3, v); chk("R6 data", v, 32'h0);
      bus_read(3'd1, v); chk("R6 nsel", v, 32'h0);

      // R6 soft reset beats a done pulse
      @(negedge clk);
      bus_addr = 3'd4; bus_wdata = 32'h0; bus_wr = 1'b1;
      conv_done = 1'b1; conv_result = 12'h0AA;
      @(negedge clk);
      bus_wr = 1'b0; conv_done = 1'b0;
      #1 chk("R6 priority irq", 32'(adc_irq), 32'h0);
      bus_read(3'd3, v); chk("R6 priority data", v, 32'h0);

      finish_run();
   end
endmodule